// File: doc/BRIEF.md
# Timer Channel Compare Output

This block is a single timer channel. It holds an up/down counter with a programmable wrap value and a programmable compare value. It derives an active-high reference level from how the counter and the compare value relate. A 3-bit behaviour code selects one of eight ways to form that level:

- hold the level (frozen);
- set, clear or toggle the level on a match;
- force the level low or high;
- one of two pulse-width modes, whose sense follows the count direction.

Two pins leave the block, each with its own polarity bit:

- a main output, which follows the reference level;
- a complementary output, which is its inverse.

Software-style configuration arrives over a small write port. The port has a 2-bit address and a data word as wide as the counter. Every register starts at zero, so after reset the channel is frozen with a low reference. The counter advances only while the count-enable input is high.

Top module: `tmrcmp_top`

## Requirements
- R1: After reset the counter reads 0, the reference is low, the mode is frozen and both polarity bits are 0, so the main output is 0 and the complementary output is 1.
- R2: A write with address 0 loads the control word. In that word, bits 6:4 hold the behaviour code, bit 0 selects down counting when 1, bit 1 is the main polarity and bit 2 is the complementary polarity. Address 1 loads the compare value and address 2 loads the wrap value. A write to address 3 changes nothing. A write takes effect from the next clock.
- R3: With count enable high, counting up goes from the wrap value to 0 and otherwise adds 1. Counting down goes from 0 to the wrap value and otherwise subtracts 1. With count enable low, the counter holds.
- R4: Code 000 (frozen) keeps the reference at its current level whatever the counter does.
- R5: Code 001 drives the reference high, and code 010 drives it low, one clock after the counter shows the compare value.
- R6: Code 011 inverts the reference one clock after the counter first shows the compare value. A match that persists because the counter is held inverts it only once.
- R7: Code 100 forces the reference low and code 101 forces it high, from the next clock, regardless of the comparison.
- R8: Code 110, counting up, targets high while the counter is below the compare value. Counting down, it targets low while the counter is above the compare value and high otherwise. The reference follows that target one clock later.
- R9: Code 111 targets the inverse of code 110 in both directions.
- R10: In codes 110 and 111 the reference takes a new value only when the previous code was 000, or when the target level differs from the one of the clock before. Entering from another code with an unchanged target leaves the reference as it was.
- R11: The main output equals the reference XOR the main polarity. The complementary output equals the inverted reference XOR the complementary polarity.
- R12: In code 110 counting up, a compare value of 0 keeps the reference low. A compare value above the wrap value keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Write strobe |
| wrAddr | input | 2 | Register select: 0 control, 1 compare, 2 wrap |
| wrData | input | W | Write data |
| cntEn | input | 1 | Counter advance enable |
| cntOut | output | W | Current counter value |
| refOut | output | 1 | Active-high reference level |
| mainOut | output | 1 | Main output after polarity |
| compOut | output | 1 | Complementary output after polarity |

## Verification
The bench holds the counter on the compare value while in toggle mode. A design that toggles on every matching cycle would then oscillate instead of inverting once.

It moves from force-high into pulse-width mode with a compare value of 0. A design that refreshes on any entry to PWM would drop the reference, when it should stay high until the comparison changes.

It measures duty cycles over whole periods in both directions and both PWM senses. An off-by-one compare (≤ instead of <) or a wrong down-count sense shows up as a wrong count of high cycles.

It also tries the edge compare values 0 and above-wrap, and writes to the unused address.

// File: rtl/tmrcmp_pkg.sv
package tmrcmp_pkg;

  typedef enum logic [2:0] {
    MODE_FROZEN = 3'b000,
    MODE_SET    = 3'b001,
    MODE_CLEAR  = 3'b010,
    MODE_TOGGLE = 3'b011,
    MODE_FLOW   = 3'b100,
    MODE_FHIGH  = 3'b101,
    MODE_PWM0   = 3'b110,
    MODE_PWM1   = 3'b111
  } cmpMode_e;

  localparam int MODE_LSB  = 4;
  localparam int MODE_BITS = 3;
  localparam int DIR_BIT   = 0;
  localparam int MPOL_BIT  = 1;
  localparam int CPOL_BIT  = 2;

  localparam logic [1:0] ADDR_CTRL   = 2'd0;
  localparam logic [1:0] ADDR_CMP    = 2'd1;
  localparam logic [1:0] ADDR_RELOAD = 2'd2;

  // strobes from control to datapath
  typedef struct packed {
    logic ldCmp;
    logic ldReload;
    logic cntDown;
  } dpCtl_t;

  // comparison results from datapath to control
  typedef struct packed {
    logic eq;
    logic lt;
    logic gt;
  } cmpFlags_t;

endpackage

// File: rtl/tmrcmp_datapath.sv
module tmrcmp_datapath
  import tmrcmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         cntEn,
  input  logic [W-1:0] wrData,
  input  dpCtl_t       dpCtl,
  output cmpFlags_t    flags,
  output logic [W-1:0] cntOut
);

  localparam logic [W-1:0] ONE  = W'(1);
  localparam logic [W-1:0] ZERO = '0;

  logic [W-1:0] cmpQ;
  logic [W-1:0] reloadQ;
  logic [W-1:0] cntQ;
  logic [W-1:0] cntNext;

  always_comb begin
    cntNext = cntQ;
    if (cntEn) begin
      if (dpCtl.cntDown) begin
        cntNext = (cntQ == ZERO) ? reloadQ : cntQ - ONE;
      end else begin
        cntNext = (cntQ == reloadQ) ? ZERO : cntQ + ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpQ    <= '0;
      reloadQ <= '0;
      cntQ    <= '0;
    end else begin
      cntQ <= cntNext;
      if (dpCtl.ldCmp)    cmpQ    <= wrData;
      if (dpCtl.ldReload) reloadQ <= wrData;
    end
  end

  always_comb begin
    flags.eq = (cntQ == cmpQ);
    flags.lt = (cntQ <  cmpQ);
    flags.gt = (cntQ >  cmpQ);
  end

  assign cntOut = cntQ;

endmodule

// File: rtl/tmrcmp_ctrl.sv
module tmrcmp_ctrl
  import tmrcmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  input  cmpFlags_t    flags,
  output dpCtl_t       dpCtl,
  output logic         refOut,
  output logic         mainPol,
  output logic         compPol,
  output logic [2:0]   modeOut
);

  cmpMode_e modeQ;
  cmpMode_e prevModeQ;
  logic     downQ;
  logic     mainPolQ;
  logic     compPolQ;
  logic     refQ;
  logic     matchDlyQ;
  logic     lvlDlyQ;

  logic     ctrlWr;
  logic     pwm0Lvl;
  logic     lvl;
  logic     matchEvt;
  logic     pwmUpd;
  logic     refNext;

  assign ctrlWr = wrEn && (wrAddr == ADDR_CTRL);

  always_comb begin
    dpCtl.ldCmp    = wrEn && (wrAddr == ADDR_CMP);
    dpCtl.ldReload = wrEn && (wrAddr == ADDR_RELOAD);
    dpCtl.cntDown  = downQ;
  end

  // PWM target level for the current direction and mode
  assign pwm0Lvl  = downQ ? !flags.gt : flags.lt;
  assign lvl      = (modeQ == MODE_PWM1) ? !pwm0Lvl : pwm0Lvl;
  assign matchEvt = flags.eq && !matchDlyQ;
  assign pwmUpd   = (prevModeQ == MODE_FROZEN) || (lvl != lvlDlyQ);

  always_comb begin
    refNext = refQ;
    unique case (modeQ)
      MODE_FROZEN: refNext = refQ;
      MODE_SET:    if (matchEvt) refNext = 1'b1;
      MODE_CLEAR:  if (matchEvt) refNext = 1'b0;
      MODE_TOGGLE: if (matchEvt) refNext = !refQ;
      MODE_FLOW:   refNext = 1'b0;
      MODE_FHIGH:  refNext = 1'b1;
      MODE_PWM0,
      MODE_PWM1:   if (pwmUpd) refNext = lvl;
      default:     refNext = refQ;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ     <= MODE_FROZEN;
      prevModeQ <= MODE_FROZEN;
      downQ     <= 1'b0;
      mainPolQ  <= 1'b0;
      compPolQ  <= 1'b0;
      refQ      <= 1'b0;
      matchDlyQ <= 1'b0;
      lvlDlyQ   <= 1'b0;
    end else begin
      refQ      <= refNext;
      prevModeQ <= modeQ;
      matchDlyQ <= flags.eq;
      lvlDlyQ   <= lvl;
      if (ctrlWr) begin
        modeQ    <= cmpMode_e'(wrData[MODE_LSB +: MODE_BITS]);
        downQ    <= wrData[DIR_BIT];
        mainPolQ <= wrData[MPOL_BIT];
        compPolQ <= wrData[CPOL_BIT];
      end
    end
  end

  assign refOut  = refQ;
  assign mainPol = mainPolQ;
  assign compPol = compPolQ;
  assign modeOut = modeQ;

endmodule

// File: rtl/tmrcmp_top.sv
module tmrcmp_top
  import tmrcmp_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         wrEn,
  input  logic [1:0]   wrAddr,
  input  logic [W-1:0] wrData,
  input  logic         cntEn,
  output logic [W-1:0] cntOut,
  output logic         refOut,
  output logic         mainOut,
  output logic         compOut
);

  dpCtl_t     dpCtl;
  cmpFlags_t  flags;
  logic       mainPol;
  logic       compPol;
  logic [2:0] modeSig;

  tmrcmp_datapath #(.W(W)) dp_i (
    .clk    (clk),
    .rstN   (rstN),
    .cntEn  (cntEn),
    .wrData (wrData),
    .dpCtl  (dpCtl),
    .flags  (flags),
    .cntOut (cntOut)
  );

  tmrcmp_ctrl #(.W(W)) ctrl_i (
    .clk     (clk),
    .rstN    (rstN),
    .wrEn    (wrEn),
    .wrAddr  (wrAddr),
    .wrData  (wrData),
    .flags   (flags),
    .dpCtl   (dpCtl),
    .refOut  (refOut),
    .mainPol (mainPol),
    .compPol (compPol),
    .modeOut (modeSig)
  );

  assign mainOut = refOut ^ mainPol;
  assign compOut = !refOut ^ compPol;

endmodule

// File: rtl/tmrcmp_chk.sv
module tmrcmp_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rstN,
  input logic         cntEn,
  input logic [W-1:0] cntOut,
  input logic         refOut,
  input logic [2:0]   modeQ,
  input logic         cntDown,
  input logic         eqFlag
);

  AST_FORCE_LOW: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 3'b100) |=> !refOut); // R7

  AST_FORCE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 3'b101) |=> refOut); // R7

  AST_FROZEN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 3'b000) |=> $stable(refOut)); // R4

  AST_SET_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 3'b001 && eqFlag) |=> refOut); // R5

  AST_CLEAR_ON_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    (modeQ == 3'b010 && eqFlag) |=> !refOut); // R5

  AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !cntEn |=> $stable(cntOut)); // R3

  AST_CNT_UP_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (cntEn && !cntDown) |=> (cntOut == $past(cntOut) + W'(1)) || (cntOut == '0)); // R3

endmodule

bind tmrcmp_top tmrcmp_chk #(.W(W)) chk_i (
  .clk     (clk),
  .rstN    (rstN),
  .cntEn   (cntEn),
  .cntOut  (cntOut),
  .refOut  (refOut),
  .modeQ   (modeSig),
  .cntDown (dpCtl.cntDown),
  .eqFlag  (flags.eq)
);

// File: tb/tmrcmp_top_tb_top.sv
module tmrcmp_top_tb_top;

  localparam int W = 16;
  localparam int MASK = (1 << W) - 1;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrEn = 1'b0;
  logic [1:0]   wrAddr = 2'd0;
  logic [W-1:0] wrData = '0;
  logic         cntEn = 1'b0;
  logic [W-1:0] cntOut;
  logic         refOut, mainOut, compOut;

  int tests = 0;
  int fails = 0;
  string phase = "R1";
  bit doneFlag = 0;

  always #10 clk = ~clk;

  tmrcmp_top #(.W(W)) dut_i (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .cntEn(cntEn), .cntOut(cntOut), .refOut(refOut),
    .mainOut(mainOut), .compOut(compOut)
  );

  // behavioural reference model
  int mCnt, mCmp, mRel, mMode, mPrev;
  bit mDown, mMp, mCp, mRef, mMatchD, mLvlD;

  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mCmp = 0; mRel = 0; mMode = 0; mPrev = 0;
      mDown = 0; mMp = 0; mCp = 0; mRef = 0; mMatchD = 0; mLvlD = 0;
    end else begin
      bit match, p0, lvl, evt, nRef;
      int nCnt;
      match = (mCnt == mCmp);
      p0 = mDown ? (mCnt <= mCmp) : (mCnt < mCmp);
      lvl = (mMode == 7) ? !p0 : p0;
      evt = match && !mMatchD;
      nRef = mRef;
      case (mMode)
        1: if (evt) nRef = 1;
        2: if (evt) nRef = 0;
        3: if (evt) nRef = !mRef;
        4: nRef = 0;
        5: nRef = 1;
        6, 7: if (mPrev == 0 || lvl != mLvlD) nRef = lvl;
        default: nRef = mRef;
      endcase
      nCnt = mCnt;
      if (cntEn) begin
        if (mDown) nCnt = (mCnt == 0) ? mRel : mCnt - 1;
        else       nCnt = (mCnt == mRel) ? 0 : (mCnt + 1) & MASK;
      end
      mPrev = mMode; mMatchD = match; mLvlD = lvl; mRef = nRef; mCnt = nCnt;
      if (wrEn) begin
        case (wrAddr)
          2'd0: begin
            mMode = (int'(wrData) >> 4) & 7;
            mDown = wrData[0]; mMp = wrData[1]; mCp = wrData[2];
          end
          2'd1: mCmp = int'(wrData);
          2'd2: mRel = int'(wrData);
          default: ;
        endcase
      end
    end
  end

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rstN && !doneFlag) begin
      tests++;
      if (int'(cntOut) != mCnt || refOut != mRef ||
          mainOut != (mRef ^ mMp) || compOut != (!mRef ^ mCp)) begin
        fails++;
        $display("FAIL %s cycle: cnt=%0d ref=%0b main=%0b comp=%0b exp cnt=%0d ref=%0b main=%0b comp=%0b",
                 phase, cntOut, refOut, mainOut, compOut, mCnt, mRef, mRef ^ mMp, !mRef ^ mCp);
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input int d);
    wrEn = 1'b1; wrAddr = a; wrData = W'(d);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic int ctl(input int mode, input bit dn, input bit mp, input bit cp);
    return (mode << 4) | (int'(cp) << 2) | (int'(mp) << 1) | int'(dn);
  endfunction

  task automatic duty(input int per, input int exp, input string tag);
    int hi = 0;
    for (int i = 0; i < per; i++) begin
      @(negedge clk);
      if (refOut) hi++;
    end
    chk(hi == exp, tag, hi, exp);
  endtask

  initial begin
    #4_000_000;
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    // R1 reset state
    chk(cntOut == 0, "R1 cnt", cntOut, 0);
    chk(refOut == 0, "R1 ref", refOut, 0);
    chk(mainOut == 0 && compOut == 1, "R1 outputs", {mainOut, compOut}, 1);

    // R3 counting up, frozen
    phase = "R3";
    wr(2'd2, 5); wr(2'd1, 3); cntEn = 1'b1;
    cyc(14);
    phase = "R4";
    cyc(4);
    chk(refOut == 0, "R4 frozen low", refOut, 0);

    // R5 set then clear
    phase = "R5";
    wr(2'd0, ctl(1, 0, 0, 0)); cyc(8);
    chk(refOut == 1, "R5 set", refOut, 1);
    wr(2'd0, ctl(2, 0, 0, 0)); cyc(8);
    chk(refOut == 0, "R5 clear", refOut, 0);

    // R6 toggle, with the counter held on the match
    phase = "R6";
    wr(2'd0, ctl(3, 0, 0, 0)); cyc(20);
    for (int i = 0; i < 10 && cntOut != 3; i++) @(negedge clk);
    cntEn = 1'b0;
    cyc(3);
    begin
      bit held = refOut;
      cyc(6);
      chk(refOut == held, "R6 single toggle", refOut, held);
    end
    cntEn = 1'b1; cyc(6);

    // R7 force low/high
    phase = "R7";
    wr(2'd0, ctl(4, 0, 0, 0)); cyc(5);
    chk(refOut == 0, "R7 force low", refOut, 0);
    wr(2'd0, ctl(5, 0, 0, 0)); cyc(5);
    chk(refOut == 1, "R7 force high", refOut, 1);

    // R11 polarity
    phase = "R11";
    wr(2'd0, ctl(5, 0, 1, 1)); cyc(2);
    chk(mainOut == 0 && compOut == 1, "R11 inverted high", {mainOut, compOut}, 1);
    wr(2'd0, ctl(4, 0, 1, 1)); cyc(2);
    chk(mainOut == 1 && compOut == 0, "R11 inverted low", {mainOut, compOut}, 2);

    // R2 address 3 ignored (data would mean force high)
    phase = "R2";
    wr(2'd3, ctl(5, 0, 0, 0)); cyc(3);
    chk(refOut == 0 && mainOut == 1, "R2 addr3 ignored", refOut, 0);

    // R8 PWM0 up and down, compare 2, period 6
    phase = "R8";
    wr(2'd0, ctl(0, 0, 0, 0)); wr(2'd1, 2);
    wr(2'd0, ctl(6, 0, 0, 0)); cyc(8);
    duty(6, 2, "R8 pwm0 up duty");
    wr(2'd0, ctl(6, 1, 0, 0)); cyc(12);
    duty(6, 3, "R8 pwm0 down duty");

    // R9 PWM1 inverse
    phase = "R9";
    wr(2'd0, ctl(7, 0, 0, 0)); cyc(8);
    duty(6, 4, "R9 pwm1 up duty");
    wr(2'd0, ctl(7, 1, 0, 0)); cyc(12);
    duty(6, 3, "R9 pwm1 down duty");

    // R10 entry from force high with an unchanged target keeps level
    phase = "R10";
    wr(2'd0, ctl(5, 0, 0, 0)); wr(2'd1, 0); cyc(3);
    wr(2'd0, ctl(6, 0, 0, 0)); cyc(15);
    chk(refOut == 1, "R10 no refresh", refOut, 1);

    // R12 compare edge values
    phase = "R12";
    wr(2'd0, ctl(0, 0, 0, 0)); wr(2'd0, ctl(6, 0, 0, 0)); cyc(3);
    duty(12, 0, "R12 cmp zero low");
    wr(2'd1, 9); cyc(3);
    duty(12, 12, "R12 cmp above wrap high");

    // R4 frozen keeps the high level
    phase = "R4";
    wr(2'd0, ctl(0, 0, 0, 0)); wr(2'd1, 0); cyc(10);
    chk(refOut == 1, "R4 frozen high", refOut, 1);

    doneFlag = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule